// File: doc/BRIEF.md
# BCD Calendar Clock Register File

This block is a byte-wide storage array whose eight highest addresses hold a running time-of-day and calendar rather than plain storage. A host uses a small synchronous bus with active-low chip enable, output enable and write enable, an address and separate write and read data ports. A single-cycle `tick` input, pulsed once per second, advances the clock. The block has no oscillator of its own.

Every time field is packed BCD. The tens digit sits above the units nibble. Seconds, minutes, hours (24-hour), day of week, date, month, year and century each share a byte with control or flag bits or with spare bits. The spare bits behave as plain storage. Three control bits change how the clock runs. A stop bit halts counting. A hold bit halts counting and opens the time fields to host writes. A freeze bit gives the host a steady snapshot to read while counting continues underneath.

All addresses below the top eight are ordinary read/write bytes.

Top module: `rtc_bcd_regs`

## Requirements
- R1: With ADDR_W=8, addresses 0x00 to 0xF7 are plain bytes that return the last value written. The clock bytes are at 0xF8 + offset: 0 control/century, 1 seconds, 2 minutes, 3 hours, 4 day, 5 date, 6 month, 7 year.
- R2: A read occurs when ce_n=0, oe_n=0 and we_n=1. In the following cycle rd_en=1 and rdata holds the byte as it stood before that clock edge. In any other cycle rd_en=0 and rdata=0x00. A write occurs when ce_n=0 and we_n=0, whatever oe_n is.
- R3: The clock bytes read back with these layouts:
  - control: {hold, freeze, century[5:0]}
  - seconds: {stop, sec[6:0]}
  - minutes: {spare, min[6:0]}
  - hours: {spare[1:0], hour[5:0]}
  - day: {battery, ftest, spare[2:0], day[2:0]}
  - date: {spare[1:0], date[5:0]}
  - month: {spare[2:0], month[4:0]}
  - year: year[7:0]
- R4: Each tick advances seconds unless the clock is stopped or held. Seconds 59 goes to 00 and carries to minutes. Minutes 59 carries to hours. Hours 23 goes to 00 and carries to both day and date. Month 12 goes to 01 and carries to year. Year 99 goes to 00 and carries to century. Century 39 goes to 00.
- R5: The date wraps to 01 after the last day of the month: 30 for months 04, 06, 09 and 11, 31 for the other long months, 29 for month 02 when the year value is divisible by 4, and 28 otherwise.
- R6: Day of week goes from 07 to 01 when the date advances.
- R7: While the stop bit (seconds bit 7) is 1, ticks leave all time fields unchanged.
- R8: While the hold bit (control bit 7) is 1, ticks are dropped. Writes to time fields take effect only if hold was 1 before that clock edge, and are ignored otherwise. Once hold is cleared, counting continues from the loaded values.
- R9: When the freeze bit (control bit 6) goes from 0 to 1, the time fields are captured. While it stays 1, reads of time fields return the capture and counting continues. Once it is cleared, reads return the live time.
- R10: The spare bits and the ftest bit (day bit 6) store and return what was written. They are writable whether or not hold is set, and have no other effect.
- R11: The battery bit (day bit 7) always reads 1, and writes to it are ignored.
- R12: Reset sets the time to 00:00:00, day 01, date 01, month 01, year 00, century 20. It clears stop, hold, freeze, ftest, all spare bits and all plain bytes.
- R13: When a tick and a write to a clock byte fall in the same cycle, the tick advance is applied first. The written fields then replace their counterparts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| tick | input | 1 | One-cycle pulse per second |
| rdata | output | 8 | Read data, zero when not reading |
| rd_en | output | 1 | Read data valid (output enable) |

## Verification
A wrong internal state shows up only when the host reads the affected byte. The bench therefore keeps a behavioural model of the whole register file and compares rdata and rd_en on every cycle. It issues reads densely around each carry boundary. A bad carry is then visible one cycle after the tick that caused it. A stale snapshot or a lost spare bit shows up on the next read of that byte.

Month-end, leap-year, year and century rollovers are each set up through the hold bit and run across their boundary. A long mixed run follows, with reads, ticks and storage writes interleaved.

// File: rtl/rtc_bcd_pkg.sv
package rtc_bcd_pkg;

    localparam int CLK_BYTES = 8;

    localparam logic [2:0] OFF_CTRL = 3'd0;
    localparam logic [2:0] OFF_SEC  = 3'd1;
    localparam logic [2:0] OFF_MIN  = 3'd2;
    localparam logic [2:0] OFF_HOUR = 3'd3;
    localparam logic [2:0] OFF_DAY  = 3'd4;
    localparam logic [2:0] OFF_DATE = 3'd5;
    localparam logic [2:0] OFF_MON  = 3'd6;
    localparam logic [2:0] OFF_YEAR = 3'd7;

    // time of day, one BCD byte per field, unused high bits kept zero
    typedef struct packed {
        logic [7:0] cen;
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] day;
        logic [7:0] date;
        logic [7:0] mon;
        logic [7:0] year;
    } tod_t;

    localparam tod_t TOD_RESET = '{cen: 8'h20, sec: 8'h00, min: 8'h00, hour: 8'h00,
                                   day: 8'h01, date: 8'h01, mon: 8'h01, year: 8'h00};

    // last date of a month, BCD in and out
    function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] year);
        logic [7:0] ybin;
        ybin = ({4'b0, year[7:4]} * 8'd10) + {4'b0, year[3:0]};
        case (mon)
            8'h02:                      month_last = (ybin[1:0] == 2'b00) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: month_last = 8'h30;
            default:                    month_last = 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_bcd_step.sv
module rtc_bcd_step #(
    parameter int W = 8
) (
    input  logic [W-1:0] val,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    input  logic         en,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] ONE    = W'(1);
    localparam logic [W-5:0] ONE_HI = (W-4)'(1);

    always_comb begin
        if (!en)                 nxt = val;
        else if (val == hi)      nxt = lo;
        else if (val[3:0] == 4'd9) nxt = {val[W-1:4] + ONE_HI, 4'd0};
        else                     nxt = val + ONE;
    end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_bcd_pkg::*;
(
    input  tod_t cur,
    input  logic run,
    output tod_t nxt
);
    localparam int STAGES = 8;
    localparam int S_SEC = 0, S_MIN = 1, S_HOUR = 2, S_DAY = 3;
    localparam int S_DATE = 4, S_MON = 5, S_YEAR = 6, S_CEN = 7;

    logic [STAGES-1:0][7:0] fv, flo, fhi, fn;
    logic [STAGES-1:0]      fen;
    logic [7:0]             last_date;
    logic c_sec, c_min, c_hour, c_date, c_mon, c_year;

    always_comb begin
        last_date = month_last(cur.mon, cur.year);
        // carries come straight from the current value, not from stage outputs
        c_sec  = run    && (cur.sec  == 8'h59);
        c_min  = c_sec  && (cur.min  == 8'h59);
        c_hour = c_min  && (cur.hour == 8'h23);
        c_date = c_hour && (cur.date == last_date);
        c_mon  = c_date && (cur.mon  == 8'h12);
        c_year = c_mon  && (cur.year == 8'h99);

        fv[S_SEC]  = cur.sec;  flo[S_SEC]  = 8'h00; fhi[S_SEC]  = 8'h59;      fen[S_SEC]  = run;
        fv[S_MIN]  = cur.min;  flo[S_MIN]  = 8'h00; fhi[S_MIN]  = 8'h59;      fen[S_MIN]  = c_sec;
        fv[S_HOUR] = cur.hour; flo[S_HOUR] = 8'h00; fhi[S_HOUR] = 8'h23;      fen[S_HOUR] = c_min;
        fv[S_DAY]  = cur.day;  flo[S_DAY]  = 8'h01; fhi[S_DAY]  = 8'h07;      fen[S_DAY]  = c_hour;
        fv[S_DATE] = cur.date; flo[S_DATE] = 8'h01; fhi[S_DATE] = last_date;  fen[S_DATE] = c_hour;
        fv[S_MON]  = cur.mon;  flo[S_MON]  = 8'h01; fhi[S_MON]  = 8'h12;      fen[S_MON]  = c_date;
        fv[S_YEAR] = cur.year; flo[S_YEAR] = 8'h00; fhi[S_YEAR] = 8'h99;      fen[S_YEAR] = c_mon;
        fv[S_CEN]  = cur.cen;  flo[S_CEN]  = 8'h00; fhi[S_CEN]  = 8'h39;      fen[S_CEN]  = c_year;
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        rtc_bcd_step #(.W(8)) u_step (
            .val (fv[g]),
            .lo  (flo[g]),
            .hi  (fhi[g]),
            .en  (fen[g]),
            .nxt (fn[g])
        );
    end

    always_comb begin
        nxt.sec  = fn[S_SEC];
        nxt.min  = fn[S_MIN];
        nxt.hour = fn[S_HOUR];
        nxt.day  = fn[S_DAY];
        nxt.date = fn[S_DATE];
        nxt.mon  = fn[S_MON];
        nxt.year = fn[S_YEAR];
        nxt.cen  = fn[S_CEN];
    end
endmodule

// File: rtl/rtc_store.sv
module rtc_store #(
    parameter int ADDR_W = 8,
    parameter int DEPTH  = 248
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rd
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'h00;
        end else if (we && (addr <= LAST)) begin
            mem_q[addr] <= wdata;
        end
    end

    always_comb rd = (addr <= LAST) ? mem_q[addr] : 8'h00;
endmodule

// File: rtl/rtc_bcd_regs.sv
module rtc_bcd_regs
    import rtc_bcd_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              tick,
    output logic [7:0]        rdata,
    output logic              rd_en
);
    localparam int DEPTH     = 2 ** ADDR_W;
    localparam int RAM_DEPTH = DEPTH - CLK_BYTES;

    typedef struct packed {
        tod_t       live;
        tod_t       snap;
        logic       stop;
        logic       hold;
        logic       freeze;
        logic       ftest;
        logic [2:0] mon_x;
        logic [1:0] date_x;
        logic [2:0] day_x;
        logic [1:0] hour_x;
        logic       min_x;
        logic       rd_en;
        logic [7:0] rdata;
    } state_t;

    state_t q, d;

    logic       rd_cyc, wr_cyc, is_clk, wr_clk, wr_ram, run;
    logic [2:0] off;
    logic [7:0] ram_rd, clk_byte;
    tod_t       adv, vis;

    assign rd_cyc = !ce_n && !oe_n && we_n;
    assign wr_cyc = !ce_n && !we_n;
    assign is_clk = &addr[ADDR_W-1:3];
    assign off    = addr[2:0];
    assign wr_clk = wr_cyc && is_clk;
    assign wr_ram = wr_cyc && !is_clk;
    assign run    = tick && !q.stop && !q.hold;

    rtc_calendar u_cal (
        .cur (q.live),
        .run (run),
        .nxt (adv)
    );

    rtc_store #(.ADDR_W(ADDR_W), .DEPTH(RAM_DEPTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_ram),
        .addr  (addr),
        .wdata (wdata),
        .rd    (ram_rd)
    );

    always_comb begin
        vis = q.freeze ? q.snap : q.live;
        case (off)
            OFF_CTRL: clk_byte = {q.hold, q.freeze, vis.cen[5:0]};
            OFF_SEC:  clk_byte = {q.stop, vis.sec[6:0]};
            OFF_MIN:  clk_byte = {q.min_x, vis.min[6:0]};
            OFF_HOUR: clk_byte = {q.hour_x, vis.hour[5:0]};
            OFF_DAY:  clk_byte = {1'b1, q.ftest, q.day_x, vis.day[2:0]};
            OFF_DATE: clk_byte = {q.date_x, vis.date[5:0]};
            OFF_MON:  clk_byte = {q.mon_x, vis.mon[4:0]};
            default:  clk_byte = vis.year;
        endcase

        d      = q;
        d.live = adv;   // tick first, written fields override below
        if (wr_clk) begin
            case (off)
                OFF_CTRL: begin
                    d.hold   = wdata[7];
                    d.freeze = wdata[6];
                    if (q.hold) d.live.cen = {2'b00, wdata[5:0]};
                    if (wdata[6] && !q.freeze) d.snap = q.live;
                end
                OFF_SEC: begin
                    d.stop = wdata[7];
                    if (q.hold) d.live.sec = {1'b0, wdata[6:0]};
                end
                OFF_MIN: begin
                    d.min_x = wdata[7];
                    if (q.hold) d.live.min = {1'b0, wdata[6:0]};
                end
                OFF_HOUR: begin
                    d.hour_x = wdata[7:6];
                    if (q.hold) d.live.hour = {2'b00, wdata[5:0]};
                end
                OFF_DAY: begin
                    d.ftest = wdata[6];
                    d.day_x = wdata[5:3];
                    if (q.hold) d.live.day = {5'b0, wdata[2:0]};
                end
                OFF_DATE: begin
                    d.date_x = wdata[7:6];
                    if (q.hold) d.live.date = {2'b00, wdata[5:0]};
                end
                OFF_MON: begin
                    d.mon_x = wdata[7:5];
                    if (q.hold) d.live.mon = {3'b0, wdata[4:0]};
                end
                default: begin
                    if (q.hold) d.live.year = wdata;
                end
            endcase
        end

        d.rd_en = rd_cyc;
        d.rdata = rd_cyc ? (is_clk ? clk_byte : ram_rd) : 8'h00;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q        <= '0;
            q.live   <= TOD_RESET;
            q.snap   <= TOD_RESET;
        end else begin
            q <= d;
        end
    end

    assign rdata = q.rdata;
    assign rd_en = q.rd_en;

    AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_cyc |=> (!rd_en && rdata == 8'h00));                              // R2
    AST_BATT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cyc && is_clk && off == OFF_DAY) |=> rdata[7]);                   // R11
    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.stop && !wr_clk) |=> (q.live == $past(q.live)));                   // R7
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (q.hold && !wr_clk) |=> (q.live == $past(q.live)));                   // R8
    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wr_clk && q.live.sec == 8'h59) |=> (q.live.sec == 8'h00));   // R4
    AST_DAY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wr_clk && q.live.sec == 8'h59 && q.live.min == 8'h59 &&
         q.live.hour == 8'h23 && q.live.day == 8'h07) |=> (q.live.day == 8'h01)); // R6
    AST_SNAP_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        q.freeze |=> (q.snap == $past(q.snap)));                              // R9
endmodule

// File: tb/rtc_bcd_regs_test.sv
`timescale 1ns/1ps
module rtc_bcd_regs_test;
    localparam int BASE = 248;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, tick = 1'b0;
    logic [7:0] addr = 8'h00, wdata = 8'h00;
    logic [7:0] rdata;
    logic       rd_en;

    always #2.5 clk = ~clk;

    rtc_bcd_regs #(.ADDR_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .wdata(wdata), .tick(tick), .rdata(rdata), .rd_en(rd_en)
    );

    int compared = 0, mismatched = 0;
    bit finished = 0;

    // model: index 0 cen,1 sec,2 min,3 hour,4 day,5 date,6 month,7 year (binary)
    int t[8];
    int s[8];
    int m_stop, m_hold, m_frz, m_ft, m_monx, m_datex, m_dayx, m_hrx, m_minx;
    int ram[BASE];
    int exp_d, exp_en;

    function automatic int bcd(int v); return ((v / 10) << 4) | (v % 10); endfunction
    function automatic int bin(int b); return (b >> 4) * 10 + (b & 15); endfunction
    function automatic int mdays(int mo, int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic model_reset();
        t[0] = 20; t[1] = 0; t[2] = 0; t[3] = 0; t[4] = 1; t[5] = 1; t[6] = 1; t[7] = 0;
        s = t;
        m_stop = 0; m_hold = 0; m_frz = 0; m_ft = 0;
        m_monx = 0; m_datex = 0; m_dayx = 0; m_hrx = 0; m_minx = 0;
        for (int i = 0; i < BASE; i++) ram[i] = 0;
    endtask

    function automatic int rbyte(int a);
        int v[8];
        if (a < BASE) return ram[a];
        v = m_frz ? s : t;
        case (a - BASE)
            0: return (m_hold << 7) | (m_frz << 6) | bcd(v[0]);
            1: return (m_stop << 7) | bcd(v[1]);
            2: return (m_minx << 7) | bcd(v[2]);
            3: return (m_hrx << 6) | bcd(v[3]);
            4: return 128 | (m_ft << 6) | (m_dayx << 3) | v[4];
            5: return (m_datex << 6) | bcd(v[5]);
            6: return (m_monx << 5) | bcd(v[6]);
            default: return bcd(v[7]);
        endcase
    endfunction

    task automatic advance();
        t[1]++;
        if (t[1] < 60) return;
        t[1] = 0; t[2]++;
        if (t[2] < 60) return;
        t[2] = 0; t[3]++;
        if (t[3] < 24) return;
        t[3] = 0;
        t[4] = (t[4] == 7) ? 1 : t[4] + 1;
        if (t[5] != mdays(t[6], t[7])) begin t[5]++; return; end
        t[5] = 1; t[6]++;
        if (t[6] <= 12) return;
        t[6] = 1; t[7]++;
        if (t[7] < 100) return;
        t[7] = 0; t[0] = (t[0] == 39) ? 0 : t[0] + 1;
    endtask

    task automatic model_edge(bit ce, bit oe, bit we, int a, int wd, bit tk);
        int pre[8];
        int oh, orr;
        pre = t; oh = m_hold; orr = m_frz;
        exp_en = (!ce && !oe && we) ? 1 : 0;
        exp_d  = exp_en ? rbyte(a) : 0;
        if (tk && !m_stop && !m_hold) advance();
        if (!ce && !we) begin
            if (a < BASE) ram[a] = wd;
            else case (a - BASE)
                0: begin
                    m_hold = (wd >> 7) & 1; m_frz = (wd >> 6) & 1;
                    if (oh) t[0] = bin(wd & 63);
                    if (((wd >> 6) & 1) && !orr) s = pre;
                end
                1: begin m_stop = (wd >> 7) & 1; if (oh) t[1] = bin(wd & 127); end
                2: begin m_minx = (wd >> 7) & 1; if (oh) t[2] = bin(wd & 127); end
                3: begin m_hrx = (wd >> 6) & 3; if (oh) t[3] = bin(wd & 63); end
                4: begin m_ft = (wd >> 6) & 1; m_dayx = (wd >> 3) & 7; if (oh) t[4] = wd & 7; end
                5: begin m_datex = (wd >> 6) & 3; if (oh) t[5] = bin(wd & 63); end
                6: begin m_monx = (wd >> 5) & 7; if (oh) t[6] = bin(wd & 31); end
                default: if (oh) t[7] = bin(wd & 255);
            endcase
        end
    endtask

    task automatic step(bit ce, bit oe, bit we, int a, int wd, bit tk, string tag);
        ce_n = ce; oe_n = oe; we_n = we; addr = a[7:0]; wdata = wd[7:0]; tick = tk;
        @(posedge clk);
        model_edge(ce, oe, we, a, wd, tk);
        @(negedge clk);
        compared++;
        if (rd_en !== exp_en[0] || rdata !== exp_d[7:0]) begin
            mismatched++;
            $display("FAIL %s: addr=%02h actual rdata=%02h rd_en=%0b expected rdata=%02h rd_en=%0b",
                     tag, a[7:0], rdata, rd_en, exp_d[7:0], exp_en[0]);
        end
    endtask

    task automatic rd(int a, string tag);          step(0, 0, 1, a, 0, 0, tag); endtask
    task automatic rd_tick(int a, string tag);     step(0, 0, 1, a, 0, 1, tag); endtask
    task automatic wr(int a, int d, string tag);   step(0, 1, 0, a, d, 0, tag); endtask
    task automatic idle(bit tk, string tag);       step(1, 1, 1, 0, 0, tk, tag); endtask

    task automatic read_all(string tag);
        for (int k = 0; k < 8; k++) rd(BASE + k, tag);
    endtask

    task automatic set_time(int cen, int yr, int mo, int dt, int dy, int hr, int mi, int se, string tag);
        wr(BASE, 8'h80, tag);
        wr(BASE + 7, bcd(yr), tag);
        wr(BASE + 6, bcd(mo), tag);
        wr(BASE + 5, bcd(dt), tag);
        wr(BASE + 4, dy, tag);
        wr(BASE + 3, bcd(hr), tag);
        wr(BASE + 2, bcd(mi), tag);
        wr(BASE + 1, bcd(se), tag);
        wr(BASE, bcd(cen), tag);
        read_all(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: actual run still busy, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R12: reset state at the ports
        compared++;
        if (rd_en !== 1'b0 || rdata !== 8'h00) begin
            mismatched++;
            $display("FAIL R12: actual rdata=%02h rd_en=%0b expected 00/0", rdata, rd_en);
        end
        read_all("R12");

        // R1: plain storage below the clock bytes
        wr(0, 8'hA5, "R1"); wr(100, 8'h3C, "R1"); wr(BASE - 1, 8'hFF, "R1");
        rd(0, "R1"); rd(100, "R1"); rd(BASE - 1, "R1"); rd(1, "R1");

        // R2: non-read cycles leave outputs quiet
        step(0, 1, 1, 0, 0, 0, "R2");
        step(1, 0, 1, 0, 0, 0, "R2");
        step(0, 0, 0, 5, 8'h77, 0, "R2");
        rd(5, "R2");

        // R8: writes ignored without hold, ticks dropped while holding
        wr(BASE + 1, 8'h45, "R8"); rd(BASE + 1, "R8");
        wr(BASE, 8'h80, "R8");
        rd_tick(BASE + 1, "R8"); rd_tick(BASE + 1, "R8");
        wr(BASE + 1, 8'h30, "R8"); rd(BASE + 1, "R8");
        wr(BASE, 8'h20, "R8");
        rd_tick(BASE + 1, "R8"); rd(BASE + 1, "R8");

        // R4 R6 R5: full rollover into March of a non-leap year, day 07 -> 01
        set_time(20, 23, 2, 28, 7, 23, 59, 58, "R4");
        rd_tick(BASE + 1, "R4"); rd_tick(BASE + 1, "R4");
        read_all("R6");

        // R5: leap February
        set_time(20, 24, 2, 28, 3, 23, 59, 59, "R5");
        idle(1, "R5"); read_all("R5");
        set_time(20, 24, 2, 29, 3, 23, 59, 59, "R5");
        idle(1, "R5"); read_all("R5");
        set_time(20, 21, 4, 30, 5, 23, 59, 59, "R5");
        idle(1, "R5"); read_all("R5");
        set_time(20, 21, 1, 30, 5, 23, 59, 59, "R5");
        idle(1, "R5"); read_all("R5");

        // R4: year and century wrap
        set_time(20, 99, 12, 31, 2, 23, 59, 59, "R4");
        idle(1, "R4"); read_all("R4");
        set_time(39, 99, 12, 31, 2, 23, 59, 59, "R4");
        idle(1, "R4"); read_all("R4");

        // R7: stop bit
        wr(BASE + 1, 8'h80, "R7");
        rd_tick(BASE + 1, "R7"); rd_tick(BASE + 2, "R7"); idle(1, "R7");
        read_all("R7");
        wr(BASE + 1, 8'h00, "R7");
        idle(1, "R7"); rd(BASE + 1, "R7");

        // R9: freeze snapshot
        set_time(20, 25, 6, 15, 1, 10, 20, 30, "R9");
        wr(BASE, 8'h40, "R9");
        idle(1, "R9"); idle(1, "R9"); idle(1, "R9");
        read_all("R9");
        wr(BASE, 8'h40, "R9");
        idle(1, "R9"); rd(BASE + 1, "R9");
        wr(BASE, 8'h00, "R9");
        read_all("R9");

        // R10 R11: spare bits, ftest, battery flag
        wr(BASE + 4, 8'h00, "R11"); rd(BASE + 4, "R11");
        wr(BASE + 4, 8'h7F, "R10"); rd(BASE + 4, "R10");
        wr(BASE + 2, 8'h80, "R10"); wr(BASE + 3, 8'hC0, "R10");
        wr(BASE + 5, 8'hC0, "R10"); wr(BASE + 6, 8'hE0, "R10");
        read_all("R10");

        // R13: tick and write in the same cycle
        set_time(20, 25, 6, 15, 1, 10, 20, 59, "R13");
        step(0, 1, 0, BASE + 2, 8'h80, 1, "R13");
        read_all("R13");
        step(0, 1, 0, BASE + 1, 8'h80, 1, "R13");
        idle(1, "R13"); read_all("R13");
        wr(BASE + 1, 8'h00, "R13");

        // R3 R4 R5: long mixed run near a month end
        set_time(20, 28, 2, 28, 6, 23, 58, 0, "R3");
        for (int i = 0; i < 3000; i++) begin
            int op, a;
            bit tk;
            op = int'($urandom_range(0, 9));
            tk = ($urandom_range(0, 2) != 0);
            a  = int'($urandom_range(BASE, BASE + 7));
            if (op < 6)      step(0, 0, 1, a, 0, tk, "R3");
            else if (op < 8) step(0, 1, 0, int'($urandom_range(0, BASE - 1)), int'($urandom_range(0, 255)), tk, "R1");
            else if (op < 9) step(0, 0, 1, int'($urandom_range(0, BASE - 1)), 0, tk, "R1");
            else             idle(tk, "R4");
        end
        read_all("R5");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule